// File: doc/BRIEF.md
# Diskette Data/Clock Bit Serializer

This block sits between an 8-bit processing array and the serial side of a diskette drive interface. For writing, a data byte is loaded in parallel into a chain of two 4-bit shift registers. It then leaves the chain one bit per strobe, most significant bit first, on a serial data output. A matching clock-bit pattern is loaded into a second chain of two 4-bit registers in the same cycle. This pattern is not a free byte. Two control levels pick it: one that flags an address mark and one that flags the mark's next byte. With these, ordinary bytes and address-mark bytes leave with different clock bits.

For reading, separated clock bits arrive on an active-low serial input, and a strobe qualifies each one. Each bit is inverted and then shifted into the clock chain, so a stored 1 means a clock pulse was present. After eight strobes the chain holds a full clock byte, which appears in parallel on the clock-word output. The first bit received ends up in bit 7.

Top module: `dsk_bit_serializer`

## Requirements
- R1: A synchronous active-high reset clears both chains, so that clk_word reads 0x00 and ser_data_out and ser_clk_out read 0 in the cycle after reset is sampled.
- R2: When load_n is low at a clock edge, wr_byte is captured. Bits 3..0 go to the low data register and bits 7..4 to the high one, and ser_data_out then shows wr_byte bit 7.
- R3: On each edge with load_n high and shift_stb high, the data chain moves one place toward bit 7, and zero enters at bit 0. ser_data_out therefore gives wr_byte bits 7, 6, ... 0 on successive strobes, and 0 after eight strobes.
- R4: A load places the clock pattern {2'b00, next&addr, addr, next&addr, 3'b000} into clk_word (bit 7 down to bit 0). This gives 0x00 when mark_addr is 0, 0x10 when only mark_addr is 1, and 0x38 when both levels are 1.
- R5: On each strobe without a load, the clock chain shifts toward bit 7 and takes the inverse of ser_clk_n into bit 0. After eight strobes, clk_word bit 7 holds the first bit received and bit 0 the last.
- R6: At an edge where load_n is high and shift_stb is low, neither chain changes. clk_word, ser_data_out and ser_clk_out stay as they were.
- R7: When load_n is low and shift_stb is high at the same edge, the load is performed and no shift occurs.
- R8: ser_clk_out always equals clk_word bit 7. A loaded clock pattern therefore leaves serially, most significant bit first, in step with the data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_byte | input | 8 | Data byte to serialize on write |
| load_n | input | 1 | Parallel load enable, active low |
| mark_next | input | 1 | Control level: next byte of an address mark |
| mark_addr | input | 1 | Control level: address mark being written |
| shift_stb | input | 1 | Bit strobe; advances both chains |
| ser_clk_n | input | 1 | Serial clock-bit input on read, active low |
| ser_data_out | output | 1 | Serial data bit on write |
| ser_clk_out | output | 1 | Serial clock bit on write |
| clk_word | output | 8 | Collected or loaded clock bits |

## Verification
Every output comes straight from a register stage. A load, a strobe or a reset sampled at one rising edge therefore shows at the outputs right after that edge, with a latency of one cycle and no extra pipeline. The bench drives inputs on the falling edge and samples one full period later, on the next falling edge, when the single register update has settled. For serial sequences it compares after every strobe and does not wait for the end of the byte, so a bit lost or added at any place in the chain is caught at the exact step where it happens.

// File: rtl/dsk_ser_pkg.sv
package dsk_ser_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } shift_op_e;

  // Parallel load wins over a strobe in the same cycle.
  function automatic shift_op_e pick_op(input logic load_n, input logic stb);
    if (!load_n)  return OP_LOAD;
    else if (stb) return OP_SHIFT;
    else          return OP_HOLD;
  endfunction
endpackage

// File: rtl/dsk_nib_shreg.sv
module dsk_nib_shreg
  import dsk_ser_pkg::*;
#(
  parameter int W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  shift_op_e     op,
  input  logic          ser_in,
  input  logic [W-1:0]  par_in,
  output logic [W-1:0]  q
);
  function automatic logic [W-1:0] step(input logic [W-1:0] cur, input logic din);
    return {cur[W-2:0], din};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else begin
      unique case (op)
        OP_LOAD:  q <= par_in;
        OP_SHIFT: q <= step(q, ser_in);
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/dsk_mark_pattern.sv
module dsk_mark_pattern #(
  parameter int W = 4,
  parameter int N = 2
) (
  input  logic           mark_next,
  input  logic           mark_addr,
  output logic [W*N-1:0] pattern
);
  logic both_marks;
  assign both_marks = mark_next & mark_addr;

  always_comb begin
    pattern        = '0;
    pattern[W-1]   = both_marks;   // top of low register
    pattern[W]     = mark_addr;    // bottom of next register
    pattern[W+1]   = both_marks;
  end
endmodule

// File: rtl/dsk_bit_serializer.sv
module dsk_bit_serializer
  import dsk_ser_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int N_NIB = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NIB_W*N_NIB-1:0] wr_byte,
  input  logic                   load_n,
  input  logic                   mark_next,
  input  logic                   mark_addr,
  input  logic                   shift_stb,
  input  logic                   ser_clk_n,
  output logic                   ser_data_out,
  output logic                   ser_clk_out,
  output logic [NIB_W*N_NIB-1:0] clk_word
);
  localparam int BYTE_W = NIB_W * N_NIB;

  shift_op_e         op;
  logic              clk_bit_in;
  logic [BYTE_W-1:0] mark_pat;
  logic [BYTE_W-1:0] data_word;
  logic [NIB_W-1:0]  data_q [N_NIB];
  logic [NIB_W-1:0]  ck_q   [N_NIB];
  logic              data_sin [N_NIB];
  logic              ck_sin   [N_NIB];

  assign op         = pick_op(load_n, shift_stb);
  assign clk_bit_in = ~ser_clk_n;

  dsk_mark_pattern #(.W(NIB_W), .N(N_NIB)) u_pat (
    .mark_next (mark_next),
    .mark_addr (mark_addr),
    .pattern   (mark_pat)
  );

  for (genvar g = 0; g < N_NIB; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign data_sin[g] = 1'b0;
      assign ck_sin[g]   = clk_bit_in;
    end else begin : g_link
      assign data_sin[g] = data_q[g-1][NIB_W-1];
      assign ck_sin[g]   = ck_q[g-1][NIB_W-1];
    end

    dsk_nib_shreg #(.W(NIB_W)) u_data (
      .clk (clk), .rst (rst), .op (op),
      .ser_in (data_sin[g]),
      .par_in (wr_byte[g*NIB_W +: NIB_W]),
      .q      (data_q[g])
    );

    dsk_nib_shreg #(.W(NIB_W)) u_ck (
      .clk (clk), .rst (rst), .op (op),
      .ser_in (ck_sin[g]),
      .par_in (mark_pat[g*NIB_W +: NIB_W]),
      .q      (ck_q[g])
    );

    assign clk_word[g*NIB_W +: NIB_W]  = ck_q[g];
    assign data_word[g*NIB_W +: NIB_W] = data_q[g];
  end

  assign ser_data_out = data_word[BYTE_W-1];
  assign ser_clk_out  = ck_q[N_NIB-1][NIB_W-1];

  // ---------------- assertions ----------------
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (clk_word == '0) && !ser_data_out && !ser_clk_out);

  a_r2_load_msb: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> ser_data_out == $past(wr_byte[BYTE_W-1]));

  a_r4_load_pattern: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> clk_word[NIB_W] == $past(mark_addr)
             && clk_word[NIB_W-1] == $past(mark_next & mark_addr)
             && $countones(clk_word) <= 3);

  a_r5_clock_shift: assert property (@(posedge clk) disable iff (rst)
    (load_n && shift_stb) |=> clk_word == {$past(clk_word[BYTE_W-2:0]), ~$past(ser_clk_n)});

  a_r3_data_shift: assert property (@(posedge clk) disable iff (rst)
    (load_n && shift_stb) |=> ser_data_out == $past(data_word[BYTE_W-2]));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (load_n && !shift_stb) |=> $stable(clk_word) && $stable(ser_data_out));

  a_r8_clk_out_tap: assert property (@(posedge clk)
    ser_clk_out == clk_word[BYTE_W-1]);
endmodule

// File: tb/dsk_bit_serializer_bench.sv
module dsk_bit_serializer_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] wr_byte;
  logic       load_n, mark_next, mark_addr, shift_stb, ser_clk_n;
  logic       ser_data_out, ser_clk_out;
  logic [7:0] clk_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dsk_bit_serializer u_dsk_bit_serializer (
    .clk (clk), .rst (rst), .wr_byte (wr_byte), .load_n (load_n),
    .mark_next (mark_next), .mark_addr (mark_addr), .shift_stb (shift_stb),
    .ser_clk_n (ser_clk_n), .ser_data_out (ser_data_out),
    .ser_clk_out (ser_clk_out), .clk_word (clk_word)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply inputs at the falling edge, let one rising edge pass, sample at next falling edge.
  task automatic cycle(input logic ld_n, input logic stb, input logic sin_n);
    load_n = ld_n; shift_stb = stb; ser_clk_n = sin_n;
    @(negedge clk);
    load_n = 1'b1; shift_stb = 1'b0; ser_clk_n = 1'b1;
  endtask

  task automatic do_load(input logic [7:0] b, input logic nx, input logic ad);
    wr_byte = b; mark_next = nx; mark_addr = ad;
    cycle(1'b0, 1'b0, 1'b1);
  endtask

  function automatic logic [7:0] exp_pattern(input logic nx, input logic ad);
    logic both;
    both = nx & ad;
    return {2'b00, both, ad, both, 3'b000};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 clk_word", clk_word, 8'h00);
    chk("R1 ser_data_out", {7'b0, ser_data_out}, 8'h00);
    chk("R1 ser_clk_out", {7'b0, ser_clk_out}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_write(input logic [7:0] b, input logic nx, input logic ad);
    logic [7:0] pat;
    pat = exp_pattern(nx, ad);
    do_load(b, nx, ad);
    chk("R2 first bit", {7'b0, ser_data_out}, {7'b0, b[7]});
    chk("R4 pattern", clk_word, pat);
    for (int i = 1; i <= 8; i++) begin
      cycle(1'b1, 1'b1, 1'b1);
      chk("R3 data bit", {7'b0, ser_data_out}, (i < 8) ? {7'b0, b[7-i]} : 8'h00);
      chk("R8 clock bit", {7'b0, ser_clk_out}, (i < 8) ? {7'b0, pat[7-i]} : 8'h00);
    end
  endtask

  task automatic t_read(input logic [7:0] bits);
    logic [7:0] exp;
    exp = 8'h00;
    do_load(8'h00, 1'b0, 1'b0);
    for (int i = 7; i >= 0; i--) begin
      cycle(1'b1, 1'b1, ~bits[i]);
      exp = {exp[6:0], bits[i]};
      chk("R5 read shift", clk_word, exp);
    end
    chk("R5 full byte", clk_word, bits);
  endtask

  task automatic t_hold();
    logic [7:0] w;
    logic d;
    do_load(8'hC3, 1'b1, 1'b1);
    cycle(1'b1, 1'b1, 1'b0);
    w = clk_word; d = ser_data_out;
    for (int i = 0; i < 3; i++) begin
      cycle(1'b1, 1'b0, 1'b0);
      chk("R6 hold word", clk_word, w);
      chk("R6 hold data", {7'b0, ser_data_out}, {7'b0, d});
    end
  endtask

  task automatic t_priority();
    do_load(8'h00, 1'b0, 1'b0);
    wr_byte = 8'hA5; mark_next = 1'b1; mark_addr = 1'b1;
    cycle(1'b0, 1'b1, 1'b0);
    chk("R7 load wins word", clk_word, 8'h38);
    chk("R7 load wins data", {7'b0, ser_data_out}, 8'h01);
    cycle(1'b1, 1'b1, 1'b1);
    chk("R7 then shift", {7'b0, ser_data_out}, 8'h00);
    chk("R7 then shift word", clk_word, 8'h70);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; wr_byte = 8'h00; load_n = 1'b1; mark_next = 1'b0;
    mark_addr = 1'b0; shift_stb = 1'b0; ser_clk_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(8'hB6, 1'b0, 1'b0);
    t_write(8'h4D, 1'b0, 1'b1);
    t_write(8'hF1, 1'b1, 1'b1);
    t_write(8'h2A, 1'b1, 1'b0);
    t_read(8'hC5);
    t_read(8'h3A);
    t_hold();
    t_priority();
    do_load(8'h81, 1'b1, 1'b1);
    t_reset();
    finish_up();
  end

  initial begin
    #(PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule